// File: doc/BRIEF.md
# Management-Interface PHY Register Reader

This block lets a host read a PHY register over the two-wire management interface (MDC clock, bidirectional MDIO data). The host stores a 10-bit command word, a 5-bit PHY address over a 5-bit register number. It then writes a separate start register, and the block serializes a clause-22 read frame. It captures the 16 data bits the PHY drives back and puts them into a status word. That status word also carries a busy flag.

The host polls busy before it issues a command and again before it takes the result. A result of all ones or all zeros from an identifier register means that no PHY answers at that address. The block returns such values unaltered. The frame sequencer is a state machine with eight states. IDLE goes to PREAMBLE on an accepted start. PREAMBLE goes to START after the last preamble bit, START to OPCODE after two bits, OPCODE to PHYAD after two bits, PHYAD to REGAD after five, REGAD to TURN after five, TURN to DATA after two, and DATA back to IDLE after sixteen. Every transition is taken on an MDC falling edge. The DATA to IDLE transition also commits the captured word.

Top module: `mdio_read_ctrl`

## Requirements
- R1: After reset, MDC is low, the MDIO output enable is low, the status word reads zero (busy clear, result 0x0000) and the command word reads zero.
- R2: A write to the command register (address 0) stores wdata[9:5] as PHY address and wdata[4:0] as register number, readable back at address 0, and starts no activity: busy stays clear and MDC stays low.
- R3: A write to the start register (address 1) while idle sets busy (status bit 16 at address 2) from the next cycle until the frame is complete.
- R4: The frame sent on MDIO is a preamble of PRE_LEN ones (32 by default), then 0,1, then 1,0, then the PHY address and the register number, each MSB first.
- R5: The MDIO output enable is high for all bits up to the end of the register number and low for the two turnaround bits and the sixteen data bits.
- R6: MDC runs only while busy, with period 2*HALF_DIV system clocks, and exactly one MDC rising edge per frame bit (64 per frame by default). MDIO changes after an MDC falling edge and is sampled at an MDC rising edge.
- R7: The 16 data bits are assembled MSB first into status bits [15:0] when the frame ends, and held until the next frame ends. 0xFFFF and 0x0000 are returned unaltered.
- R8: A start write while busy is ignored, including one that falls in the same cycle as the frame's last falling edge. The frame in flight keeps its latched address, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 command, 1 start, 2 status |
| bus_wdata | input | 10 | Write data: [9:5] PHY address, [4:0] register number |
| bus_rdata | output | 17 | Read data for bus_addr: [16] busy, [15:0] result |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The frame-ending falling edge and a new start request can land in the same cycle. At that moment the sequencer is still in DATA, so the request has to be dropped rather than begin a second frame. The bench counts system clocks from the accepted start and places a start write exactly on that final edge. It then judges the result from the committed data, from busy clearing and from MDC staying low afterwards. A second collision, a command rewrite and start partway through a frame, is judged by the serialized address bits of the frame in flight.

// File: rtl/mdio_rd_pkg.sv
package mdio_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_START,
        ST_OPCODE,
        ST_PHYAD,
        ST_REGAD,
        ST_TURN,
        ST_DATA
    } frame_state_e;

    localparam int ADDR_W   = 2;
    localparam int FIELD_W  = 5;
    localparam int CMD_W    = 2 * FIELD_W;
    localparam int RES_W    = 16;
    localparam int STAT_W   = RES_W + 1;
    localparam int HDR_W    = 4 + CMD_W;

    localparam logic [ADDR_W-1:0] A_CMD  = 2'd0;
    localparam logic [ADDR_W-1:0] A_GO   = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tk,
    output logic fall_tk
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] div_cnt;
    logic          wrap;

    assign wrap    = en && (div_cnt == LAST);
    assign rise_tk = wrap && !mdc;
    assign fall_tk = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            mdc     <= 1'b0;
        end else if (!en) begin
            div_cnt <= '0;
            mdc     <= 1'b0;
        end else if (wrap) begin
            div_cnt <= '0;
            mdc     <= ~mdc;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assert_mdc_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc);

    assert_one_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tk |=> mdc);

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CMD_W-1:0]  bus_wdata,
    input  logic              busy,
    input  logic [RES_W-1:0]  result,
    output logic              go_req,
    output logic [FIELD_W-1:0] cmd_phy,
    output logic [FIELD_W-1:0] cmd_reg,
    output logic [STAT_W-1:0] bus_rdata
);
    logic [CMD_W-1:0] cmd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (bus_wr && bus_addr == A_CMD)
            cmd_q <= bus_wdata;
    end

    assign go_req  = bus_wr && (bus_addr == A_GO);
    assign cmd_phy = cmd_q[CMD_W-1:FIELD_W];
    assign cmd_reg = cmd_q[FIELD_W-1:0];

    always_comb begin
        unique case (bus_addr)
            A_CMD:   bus_rdata = STAT_W'(cmd_q);
            A_STAT:  bus_rdata = {busy, result};
            default: bus_rdata = '0;
        endcase
    end

    assert_cmd_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CMD && !busy) |=> !busy);

    assert_go_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && !busy) |=> busy);

    assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(result));

endmodule

// File: rtl/mdio_read_fsm.sv
module mdio_read_fsm
    import mdio_rd_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_req,
    input  logic [FIELD_W-1:0] phy,
    input  logic [FIELD_W-1:0] regn,
    input  logic               rise_tk,
    input  logic               fall_tk,
    input  logic               mdio_i,
    output logic               busy,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic [RES_W-1:0]   result
);
    localparam int MAXC  = (PRE_LEN > RES_W) ? PRE_LEN : RES_W;
    localparam int CNT_W = $clog2(MAXC);

    frame_state_e       state, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   limit;
    logic               last_bit;
    logic [HDR_W-1:0]   tx_sr;
    logic [RES_W-1:0]   rx_sr;

    // bits per phase, minus one
    always_comb begin
        unique case (state)
            ST_PREAMBLE: limit = CNT_W'(PRE_LEN - 1);
            ST_START:    limit = CNT_W'(1);
            ST_OPCODE:   limit = CNT_W'(1);
            ST_PHYAD:    limit = CNT_W'(FIELD_W - 1);
            ST_REGAD:    limit = CNT_W'(FIELD_W - 1);
            ST_TURN:     limit = CNT_W'(1);
            ST_DATA:     limit = CNT_W'(RES_W - 1);
            default:     limit = '0;
        endcase
    end

    assign last_bit = fall_tk && (cnt == limit);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (go_req)   nxt = ST_PREAMBLE;
            ST_PREAMBLE: if (last_bit) nxt = ST_START;
            ST_START:    if (last_bit) nxt = ST_OPCODE;
            ST_OPCODE:   if (last_bit) nxt = ST_PHYAD;
            ST_PHYAD:    if (last_bit) nxt = ST_REGAD;
            ST_REGAD:    if (last_bit) nxt = ST_TURN;
            ST_TURN:     if (last_bit) nxt = ST_DATA;
            ST_DATA:     if (last_bit) nxt = ST_IDLE;
        endcase
    end

    // datapath: bit counter, header shifter, capture shifter, result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            tx_sr  <= '0;
            rx_sr  <= '0;
            result <= '0;
        end else begin
            if (state == ST_IDLE)
                cnt <= '0;
            else if (fall_tk)
                cnt <= last_bit ? '0 : cnt + 1'b1;

            if (state == ST_IDLE && go_req)
                tx_sr <= {2'b01, 2'b10, phy, regn};
            else if (fall_tk && (state inside {ST_START, ST_OPCODE, ST_PHYAD, ST_REGAD}))
                tx_sr <= {tx_sr[HDR_W-2:0], 1'b0};

            if (rise_tk && state == ST_DATA)
                rx_sr <= {rx_sr[RES_W-2:0], mdio_i};

            if (state == ST_DATA && last_bit)
                result <= rx_sr;
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state)
            ST_IDLE:     begin mdio_o = 1'b0;      mdio_oe = 1'b0; end
            ST_PREAMBLE: begin mdio_o = 1'b1;      mdio_oe = 1'b1; end
            ST_START,
            ST_OPCODE,
            ST_PHYAD,
            ST_REGAD:    begin mdio_o = tx_sr[HDR_W-1]; mdio_oe = 1'b1; end
            ST_TURN,
            ST_DATA:     begin mdio_o = 1'b0;      mdio_oe = 1'b0; end
        endcase
    end

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN || state == ST_DATA) |-> !mdio_oe);

    assert_go_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_req && !last_bit) |=> busy);

    assert_drive_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fall_tk && state != ST_IDLE) |=> $stable(mdio_o));

endmodule

// File: rtl/mdio_read_ctrl.sv
module mdio_read_ctrl
    import mdio_rd_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int PRE_LEN  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [9:0]        bus_wdata,
    output logic [16:0]       bus_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic               go_req;
    logic [FIELD_W-1:0] cmd_phy;
    logic [FIELD_W-1:0] cmd_reg;
    logic               busy;
    logic [RES_W-1:0]   result;
    logic               rise_tk;
    logic               fall_tk;

    mdio_host_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .result    (result),
        .go_req    (go_req),
        .cmd_phy   (cmd_phy),
        .cmd_reg   (cmd_reg),
        .bus_rdata (bus_rdata)
    );

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (busy),
        .mdc     (mdc),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk)
    );

    mdio_read_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_req  (go_req),
        .phy     (cmd_phy),
        .regn    (cmd_reg),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .result  (result)
    );

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

endmodule

// File: tb/test_mdio_read_ctrl.sv
`timescale 1ns/1ps
module test_mdio_read_ctrl;
    localparam int HALF = 2;
    localparam int NBIT = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [9:0]  bus_wdata = '0;
    logic [16:0] bus_rdata;
    logic        mdc, mdio_i, mdio_o, mdio_oe;

    int tests = 0;
    int fails = 0;
    bit done_flag = 0;
    int cyc = 0;
    int rise_c0, rise_c1;
    logic [NBIT-1:0] cap_o, cap_oe;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial mdio_i = 1'b1;

    mdio_read_ctrl #(.HALF_DIV(HALF)) i_mdio_read_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [9:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd2;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [16:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // PHY model: records each bit at the MDC rise, drives data after falls
    task automatic phy_serve(input logic [15:0] resp);
        for (int i = 0; i < NBIT; i++) begin
            @(posedge mdc);
            if (i == 0) rise_c0 = cyc;
            if (i == 1) rise_c1 = cyc;
            #0.1;
            cap_o[i]  = mdio_o;
            cap_oe[i] = mdio_oe;
            @(negedge mdc);
            #0.1;
            if (i + 1 >= 48 && i + 1 < NBIT) mdio_i = resp[NBIT - 1 - (i + 1)];
            else mdio_i = 1'b1;
        end
    endtask

    task automatic check_frame(input logic [4:0] phy, input logic [4:0] rg, input string req);
        logic [NBIT-1:0] exp_o, exp_oe;
        logic [13:0] hdr;
        hdr = {2'b01, 2'b10, phy, rg};
        exp_o = '0; exp_oe = '0;
        for (int i = 0; i < 32; i++) begin exp_o[i] = 1'b1; exp_oe[i] = 1'b1; end
        for (int i = 0; i < 14; i++) begin exp_o[32 + i] = hdr[13 - i]; exp_oe[32 + i] = 1'b1; end
        chk(cap_o[45:0] == exp_o[45:0], {req, " R4 frame bits"}, cap_o[45:0], exp_o[45:0]);
        chk(cap_oe == exp_oe, "R5 output enable", cap_oe, exp_oe);
    endtask

    task automatic wait_idle();
        logic [16:0] d;
        for (int k = 0; k < 2000; k++) begin
            bus_read(2'd2, d);
            if (!d[16]) return;
        end
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] resp, input string req);
        logic [16:0] d;
        bus_write(2'd0, {phy, rg});
        bus_write(2'd1, 10'd0);
        bus_read(2'd2, d);
        chk(d[16] == 1'b1, "R3 busy after start", d[16], 1);
        phy_serve(resp);
        wait_idle();
        check_frame(phy, rg, req);
        bus_read(2'd2, d);
        chk(d == {1'b0, resp}, {req, " R7 result"}, d, {1'b0, resp});
    endtask

    task automatic t_reset();
        logic [16:0] d;
        bus_read(2'd2, d);
        chk(d == 17'd0, "R1 status", d, 0);
        bus_read(2'd0, d);
        chk(d == 17'd0, "R1 command", d, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_cmd_only();
        logic [16:0] d;
        bit saw_mdc = 0;
        bus_write(2'd0, {5'd19, 5'd6});
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (mdc) saw_mdc = 1;
        end
        bus_read(2'd2, d);
        chk(d[16] == 1'b0, "R2 no busy", d[16], 0);
        chk(saw_mdc == 0, "R2 no mdc", saw_mdc, 0);
        bus_read(2'd0, d);
        chk(d == {7'd0, 5'd19, 5'd6}, "R2 readback", d, {7'd0, 5'd19, 5'd6});
    endtask

    task automatic t_basic();
        do_read(5'd5, 5'd2, 16'hA55A, "basic");
        chk(rise_c1 - rise_c0 == 2 * HALF, "R6 mdc period", rise_c1 - rise_c0, 2 * HALF);
        do_read(5'd31, 5'd31, 16'h0001, "ones-addr");
    endtask

    task automatic t_nophy();
        do_read(5'd0, 5'd3, 16'hFFFF, "absent-ff");
        do_read(5'd9, 5'd2, 16'h0000, "absent-00");
    endtask

    task automatic t_go_mid();
        logic [16:0] d;
        bus_write(2'd0, {5'd12, 5'd1});
        bus_write(2'd1, 10'd0);
        fork
            phy_serve(16'h3C96);
            begin
                repeat (40) @(negedge clk);
                bus_write(2'd0, {5'd27, 5'd17});
                bus_write(2'd1, 10'd0);
            end
        join
        wait_idle();
        check_frame(5'd12, 5'd1, "R8 mid-frame start");
        bus_read(2'd2, d);
        chk(d == {1'b0, 16'h3C96}, "R8 result kept", d, {1'b0, 16'h3C96});
    endtask

    task automatic t_go_last();
        logic [16:0] d;
        bit saw_mdc = 0;
        bus_write(2'd0, {5'd4, 5'd7});
        bus_write(2'd1, 10'd0);
        fork
            phy_serve(16'h8001);
            begin
                repeat (2 * HALF * NBIT - 2) @(negedge clk);
                bus_write(2'd1, 10'd0);
            end
        join
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (mdc) saw_mdc = 1;
        end
        bus_read(2'd2, d);
        chk(d == {1'b0, 16'h8001}, "R8 start on last edge ignored", d, {1'b0, 16'h8001});
        chk(saw_mdc == 0, "R8 no second frame", saw_mdc, 0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd_only();
        t_basic();
        t_nophy();
        t_go_mid();
        t_go_last();
        finish_run();
    end
endmodule